// File: doc/BRIEF.md
# Unlock-Gated Two-Wire Configuration Loader

This block accepts configuration words on two pins that also serve as register-select inputs: a serial clock pin and a serial data pin. A fast system clock samples both pins through synchronizer chains and finds their edges internally. A loader only starts to accept a word after an unlock pattern. That pattern is a run of serial-clock rising edges taken with data high, closed by one rising edge taken with data low.

Each bit is sent twice. The inverse value appears at a serial-clock falling edge, and the true value is captured at the next rising edge. A frame holds a zero start bit, 21 payload bits sent least significant first, and three address bits sent A0 first. A stop symbol follows, which is data high at both the falling and the rising edge. When the stop is correct and the address is one that is decoded, the block raises a one-cycle write strobe. The payload and the address stay on the outputs until the next write.

Any framing fault drives an active-low error flag. The flag stays low until the next good unlock. A watchdog in system clocks drops a partial frame after an idle gap. A low power-down input refuses all programming.

Top module: `sprog_loader`

## Requirements
- R1: A frame is accepted only after at least UNLOCK_MIN (default 5) serial-clock rising edges with data high, followed immediately by one rising edge with data low. A shorter run followed by a frame gives no write.
- R2: After unlock the frame is a start bit, 21 payload bits (bit 0 first), 3 address bits (A0 first) and a stop symbol. A correct frame gives exactly one single-cycle `wr_stb`. In that cycle `wr_data` and `wr_addr` carry the payload and the address, and both hold until the next write.
- R3: Each bit is valid only when the data level at the falling edge is the inverse of the level at the following rising edge. Equal levels set the error flag and drop the frame.
- R4: The start bit must be 0, sent as data 1 at the fall and data 0 at the rise. Any other start sets the error flag and gives no write.
- R5: The stop symbol is data 1 at the fall and data 1 at the rise. A properly encoded 25th bit (a length fault) or any other non-stop symbol sets the error flag and gives no write.
- R6: Addresses 000, 001, 010, 011, 100 and 110 are written. Addresses 101 and 111 set the error flag and give no write.
- R7: `err_n` is 1 after reset. It goes to 0 on any fault of R3 to R6, and it returns to 1 only at the closing edge of a good unlock.
- R8: After each load the loader re-arms. A frame sent without a fresh unlock gives no write.
- R9: If no edge occurs on either pin for WDOG_CYC system clocks, the partial frame is dropped without a write and `err_n` is left unchanged. Gaps shorter than WDOG_CYC keep the frame alive.
- R10: While `pwr_dn_n` is 0, no write occurs and any frame in progress is dropped.
- R11: During and right after reset, `wr_stb` is 0, `wr_data` and `wr_addr` are 0, and `err_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset |
| pin_sck | input | 1 | Serial clock / select pin, asynchronous |
| pin_sdi | input | 1 | Serial data / select pin, asynchronous |
| pwr_dn_n | input | 1 | Active-low power-down; refuses programming |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 3 | Register address of the last write |
| wr_data | output | DATA_W | Payload of the last write |
| err_n | output | 1 | Active-low sticky programming error |

## Verification
The assertions assume that `pwr_dn_n` changes only away from the rising system-clock edge. They also assume that the data pin is stable for several system clocks around each serial-clock edge, so that the synchronized data level seen at an edge is the level the sender meant. The stimulus meets both conditions. It changes every input just after a falling system-clock edge, and it moves the data pin four system clocks before each serial-clock edge. Every pin edge is kept well inside the watchdog window, except where the bench leaves a gap on purpose to test the timeout.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_START = 2'd1,
      ST_BITS  = 2'd2,
      ST_STOP  = 2'd3
   } ld_state_e;

   // addresses 101 and 111 have no register behind them
   function automatic logic addr_decoded(input logic [ADDR_W-1:0] a);
      return !((a == 3'b101) || (a == 3'b111));
   endfunction
endpackage

// File: rtl/sprog_pin_sync.sv
module sprog_pin_sync #(
   parameter int STAGES = 2,
   parameter int NPINS  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_i,
   output logic [NPINS-1:0] lvl_o,
   output logic [NPINS-1:0] rise_o,
   output logic [NPINS-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sprog_pin_sync: STAGES must be at least 2");
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
         end else begin
            chain <= {chain[STAGES-2:0], pin_i[p]};
            prev  <= chain[STAGES-1];
         end
      end
      assign lvl_o[p]  = chain[STAGES-1];
      assign rise_o[p] = chain[STAGES-1] & ~prev;
      assign fall_o[p] = ~chain[STAGES-1] & prev;
   end
endmodule

// File: rtl/sprog_watchdog.sv
module sprog_watchdog #(
   parameter int LIMIT = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("sprog_watchdog: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         armed  <= 1'b0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (kick) begin
            cnt   <= '0;
            armed <= 1'b1;
         end else if (armed) begin
            if (cnt == CNT_LAST) begin
               expire <= 1'b1;
               armed  <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sprog_frame.sv
module sprog_frame
   import sprog_pkg::*;
#(
   parameter int DATA_W     = 21,
   parameter int UNLOCK_MIN = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     abort,
   input  logic                     sck_rise,
   input  logic                     sck_fall,
   input  logic                     sdi,
   output logic                     unlock_ok,
   output logic                     err_set,
   output logic                     load,
   output logic [DATA_W+ADDR_W-1:0] word
);
   localparam int WORD_W = DATA_W + ADDR_W;
   localparam int BCW    = $clog2(WORD_W);
   localparam int HCW    = $clog2(UNLOCK_MIN + 1);
   localparam logic [BCW-1:0] BIT_LAST = BCW'(WORD_W - 1);
   localparam logic [HCW-1:0] HUNT_MAX = HCW'(UNLOCK_MIN);

   if (UNLOCK_MIN < 1) begin : g_bad_unlock
      $error("sprog_frame: UNLOCK_MIN must be at least 1");
   end

   ld_state_e          st;
   logic [HCW-1:0]     hcnt;
   logic [BCW-1:0]     bcnt;
   logic               fall_val;
   logic [WORD_W-1:0]  sr;
   logic               act;
   logic               bit_ok;

   assign act    = sck_rise & ~abort;
   assign bit_ok = fall_val ^ sdi;

   always_comb begin
      unlock_ok = 1'b0;
      err_set   = 1'b0;
      load      = 1'b0;
      if (act) begin
         unique case (st)
            ST_HUNT:  unlock_ok = ~sdi & (hcnt >= HUNT_MAX);
            ST_START: err_set   = ~(fall_val & ~sdi);
            ST_BITS:  err_set   = ~bit_ok;
            ST_STOP: begin
               load    = fall_val & sdi;
               err_set = ~(fall_val & sdi);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_HUNT;
         hcnt     <= '0;
         bcnt     <= '0;
         fall_val <= 1'b0;
         sr       <= '0;
      end else if (abort) begin
         st   <= ST_HUNT;
         hcnt <= '0;
         bcnt <= '0;
      end else begin
         if (sck_fall) fall_val <= sdi;
         if (sck_rise) begin
            unique case (st)
               ST_HUNT: begin
                  if (sdi) begin
                     if (hcnt != HUNT_MAX) hcnt <= hcnt + 1'b1;
                  end else begin
                     if (hcnt >= HUNT_MAX) st <= ST_START;
                     hcnt <= '0;
                  end
               end
               ST_START: begin
                  bcnt <= '0;
                  st   <= (fall_val & ~sdi) ? ST_BITS : ST_HUNT;
               end
               ST_BITS: begin
                  if (!bit_ok) begin
                     st <= ST_HUNT;
                  end else begin
                     sr   <= {sdi, sr[WORD_W-1:1]};
                     bcnt <= bcnt + 1'b1;
                     if (bcnt == BIT_LAST) st <= ST_STOP;
                  end
               end
               ST_STOP: st <= ST_HUNT;
               default: st <= ST_HUNT;
            endcase
         end
      end
   end

   assign word = sr;
endmodule

// File: rtl/sprog_loader.sv
module sprog_loader
   import sprog_pkg::*;
#(
   parameter int DATA_W      = 21,
   parameter int UNLOCK_MIN  = 5,
   parameter int WDOG_CYC    = 250000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_sck,
   input  logic              pin_sdi,
   input  logic              pwr_dn_n,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              err_n
);
   localparam int WORD_W = DATA_W + ADDR_W;

   if (DATA_W < 1) begin : g_bad_data
      $error("sprog_loader: DATA_W must be at least 1");
   end

   logic [1:0]        lvl, rise, fall;
   logic              kick, expire, abort;
   logic              unlock_ok, err_set, load;
   logic [WORD_W-1:0] word;
   logic              addr_good;

   sprog_pin_sync #(.STAGES(SYNC_STAGES), .NPINS(2)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  ({pin_sdi, pin_sck}),
      .lvl_o  (lvl),
      .rise_o (rise),
      .fall_o (fall)
   );

   assign kick = |(rise | fall);

   sprog_watchdog #(.LIMIT(WDOG_CYC)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick   (kick),
      .expire (expire)
   );

   assign abort = expire | ~pwr_dn_n;

   sprog_frame #(.DATA_W(DATA_W), .UNLOCK_MIN(UNLOCK_MIN)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (abort),
      .sck_rise  (rise[0]),
      .sck_fall  (fall[0]),
      .sdi       (lvl[1]),
      .unlock_ok (unlock_ok),
      .err_set   (err_set),
      .load      (load),
      .word      (word)
   );

   assign addr_good = addr_decoded(word[WORD_W-1:DATA_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         err_n   <= 1'b1;
      end else begin
         wr_stb <= load & addr_good;
         if (load && addr_good) begin
            wr_addr <= word[WORD_W-1:DATA_W];
            wr_data <= word[DATA_W-1:0];
         end
         if (err_set || (load && !addr_good)) err_n <= 1'b0;
         else if (unlock_ok)                  err_n <= 1'b1;
      end
   end
endmodule

// File: rtl/sprog_loader_chk.sv
module sprog_loader_chk #(
   parameter int DATA_W = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_dn_n,
   input logic              wr_stb,
   input logic [2:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              err_n
);
   // R2
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   // R2
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data != $past(wr_data)) |-> wr_stb);
   // R6
   stb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_addr != 3'b101 && wr_addr != 3'b111));
   // R7
   stb_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> err_n);
   // R10
   pd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n |=> !wr_stb);
endmodule

bind sprog_loader sprog_loader_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwr_dn_n (pwr_dn_n),
   .wr_stb   (wr_stb),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .err_n    (err_n)
);

// File: tb/sprog_loader_bench.sv
`timescale 1ns/1ps
module sprog_loader_bench;
   localparam int DW   = 21;
   localparam int WDOG = 200;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, sdi = 1'b0, pd_n = 1'b1;
   logic          wr_stb, err_n;
   logic [2:0]    wr_addr;
   logic [DW-1:0] wr_data;

   int checks = 0, fails = 0, nwr = 0, cyc = 0, gap = 0;
   logic [2:0]    last_addr = '0;
   logic [DW-1:0] last_data = '0;

   always #4 clk = ~clk;

   sprog_loader #(.DATA_W(DW), .UNLOCK_MIN(5), .WDOG_CYC(WDOG)) u_sprog_loader (
      .clk(clk), .rst_n(rst_n), .pin_sck(sck), .pin_sdi(sdi), .pwr_dn_n(pd_n),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .err_n(err_n));

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (wr_stb) begin
         nwr       <= nwr + 1;
         last_addr <= wr_addr;
         last_data <= wr_data;
      end
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic edge_(input logic c, input logic d);
      waitc(gap);
      sdi = d; waitc(4);
      sck = c; waitc(4);
   endtask

   task automatic raw(input logic f, input logic r);
      edge_(1'b0, f); edge_(1'b1, r);
   endtask

   task automatic sbit(input logic b);
      raw(~b, b);
   endtask

   task automatic unlock(input int n);
      for (int i = 0; i < n; i++) raw(1'b1, 1'b1);
      raw(1'b0, 1'b0);
   endtask

   task automatic body(input logic [23:0] w);
      sbit(1'b0);
      for (int i = 0; i < 24; i++) sbit(w[i]);
   endtask

   task automatic frame(input logic [23:0] w);
      unlock(5); body(w); raw(1'b1, 1'b1); waitc(8);
   endtask

   localparam logic [23:0] VEC [8] = '{
      {3'b000, 21'h1A5A5}, {3'b001, 21'h0F0F0}, {3'b010, 21'h155555},
      {3'b011, 21'h1FFFFF}, {3'b100, 21'h000001}, {3'b110, 21'h100000},
      {3'b101, 21'h012345}, {3'b111, 21'h0ABCDE}};

   initial begin
      while (cyc < 150000) @(negedge clk);
      chk(1'b0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n0;
      logic [23:0] w;
      logic        vok;
      waitc(10);
      // R11 reset state
      chk(err_n == 1'b1 && wr_stb == 1'b0, "R11 reset err/stb", {err_n, wr_stb}, 2'b10);
      chk(wr_data == '0 && wr_addr == '0, "R11 reset data", int'(wr_data), 0);
      rst_n = 1'b1; waitc(5);

      // R2 R6 R7 vector table
      foreach (VEC[k]) begin
         w   = VEC[k];
         vok = !(w[23:21] == 3'b101 || w[23:21] == 3'b111);
         n0  = nwr;
         frame(w);
         if (vok) begin
            chk(nwr == n0 + 1, "R2 one write", nwr - n0, 1);
            chk(last_data == w[20:0], "R2 data", int'(last_data), int'(w[20:0]));
            chk(last_addr == w[23:21], "R6 addr", int'(last_addr), int'(w[23:21]));
            chk(err_n == 1'b1, "R7 err high", err_n, 1);
         end else begin
            chk(nwr == n0, "R6 undecoded no write", nwr - n0, 0);
            chk(err_n == 1'b0, "R6 undecoded error", err_n, 0);
         end
      end

      // R7 error stays low without unlock, cleared by good unlock
      for (int i = 0; i < 3; i++) raw(1'b1, 1'b0);
      waitc(8);
      chk(err_n == 1'b0, "R7 sticky", err_n, 0);
      frame({3'b001, 21'h000777});
      chk(err_n == 1'b1 && last_data == 21'h000777, "R7 cleared by unlock", err_n, 1);

      // R1 short unlock run
      n0 = nwr;
      unlock(4); body(24'h0); raw(1'b1, 1'b1); waitc(8);
      chk(nwr == n0, "R1 short unlock", nwr - n0, 0);
      chk(err_n == 1'b1, "R1 no error", err_n, 1);
      // R1 longer run accepted
      n0 = nwr;
      unlock(8); body({3'b010, 21'h0C0FFE}); raw(1'b1, 1'b1); waitc(8);
      chk(nwr == n0 + 1 && last_data == 21'h0C0FFE, "R1 long unlock", int'(last_data), 'h0C0FFE);

      // R8 re-arm: frame without unlock
      n0 = nwr;
      body(24'h0); raw(1'b1, 1'b1); waitc(8);
      chk(nwr == n0, "R8 rearm needed", nwr - n0, 0);

      // R4 bad start bit
      n0 = nwr;
      unlock(5); sbit(1'b1); waitc(8);
      chk(err_n == 1'b0 && nwr == n0, "R4 start bit", err_n, 0);

      // R3 bad encoding mid-payload
      n0 = nwr;
      unlock(5);
      chk(err_n == 1'b1, "R7 unlock clears", err_n, 1);
      sbit(1'b0); for (int i = 0; i < 5; i++) sbit(1'b0);
      raw(1'b1, 1'b1); waitc(8);
      chk(err_n == 1'b0 && nwr == n0, "R3 encoding", err_n, 0);

      // R5 length fault
      n0 = nwr;
      unlock(5); body(24'h0); sbit(1'b0); waitc(8);
      chk(err_n == 1'b0 && nwr == n0, "R5 length", err_n, 0);
      // R5 bad stop
      n0 = nwr;
      unlock(5); body(24'h0); raw(1'b0, 1'b0); waitc(8);
      chk(err_n == 1'b0 && nwr == n0, "R5 stop", err_n, 0);

      // R9 long but legal gaps
      gap = 150;
      n0 = nwr;
      frame({3'b011, 21'h054321});
      gap = 0;
      chk(nwr == n0 + 1 && last_data == 21'h054321, "R9 gaps kept", int'(last_data), 'h054321);
      // R9 timeout drops frame, error unchanged
      n0 = nwr;
      unlock(5); sbit(1'b0); for (int i = 0; i < 10; i++) sbit(1'b1);
      waitc(2 * WDOG);
      for (int i = 0; i < 14; i++) sbit(1'b0);
      raw(1'b1, 1'b1); waitc(8);
      chk(nwr == n0, "R9 timeout no write", nwr - n0, 0);
      chk(err_n == 1'b1, "R9 err unchanged", err_n, 1);

      // R10 power-down refuses programming
      pd_n = 1'b0;
      n0 = nwr;
      frame({3'b000, 21'h1F00F});
      chk(nwr == n0, "R10 powered down", nwr - n0, 0);
      pd_n = 1'b1; waitc(4);
      frame({3'b100, 21'h00ABC});
      chk(nwr == n0 + 1 && last_addr == 3'b100, "R10 after release", int'(last_addr), 4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule